// File: doc/BRIEF.md
# SD Card Interface Power Sequencer

This block owns the electrical state of the card-side pads of an SD/MMC host. Software writes a two-bit power code and a transceiver polarity bit. The block drives the clock, command and data pads through four states: tri-stated after reset, all lines forced low for a power cycle, all lines held high while off, and powered on.

In the powered state the card clock reaches the pad at once. The command and data pads stay driven high until the card has received a fixed number of initial clock cycles. Only then are the pads handed to the host datapath and the host is told it may run. Card-clock cycles arrive as single-cycle pulses on `card_tick`, which the host clock generator produces. The current code and polarity can be read back, and the host sees a ready flag.

Top module: `sdpwr_seq_top`

## Requirements
- R1: After a synchronous reset, `stat_code` is 00, `stat_dirinv` is 0, `host_ready` is 0, both direction outputs are 0 and every pad output enable is 0.
- R2: Writing code 10 from any state enters power-cycle. `stat_code` reads 10, every pad enable is 1 and the clock, command and data levels are all 0.
- R3: Writing code 00 from power-cycle or power-on enters power-off. `stat_code` reads 00, every pad enable is 1 and every level is 1. Writing 00 from the reset state keeps the pads tri-stated.
- R4: Code 11 is accepted only from power-off, and from power-on it keeps that state. From the reset or power-cycle state the write leaves the state unchanged.
- R5: A write with the reserved code 01 changes neither the state nor the polarity bit.
- R6: In power-on, `host_ready` stays 0 until INIT_CYC `card_tick` pulses have been sampled in that state, and reads 1 in the cycle after the edge that samples the last one. Until then the clock pad follows `host_ck`, while command and data are driven high.
- R7: With `host_ready` high, the command pad takes `host_cmd_o`/`host_cmd_oe` and each data lane takes `host_dat_o`/`host_dat_oe`. The pads lag those inputs by one cycle.
- R8: Leaving power-on clears `host_ready` and the tick count. A later power-on again needs INIT_CYC fresh pulses.
- R9: `xcvr_cmd_dir` equals the command pad enable XOR the polarity bit, and `xcvr_dat_dir` equals the data pad enable XOR the polarity bit.
- R10: Every write with a non-reserved code captures `cfg_dirinv` into the polarity bit, shown on `stat_dirinv`. This holds even when the code is refused under R4.
- R11: A reset applied in any state returns the block to the R1 condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high peripheral reset |
| cfg_wr | input | 1 | Write strobe for the power code and polarity |
| cfg_code | input | 2 | Power code: 00 off, 10 cycle, 11 on, 01 reserved |
| cfg_dirinv | input | 1 | Transceiver direction polarity to store |
| card_tick | input | 1 | One pulse per card-clock cycle |
| host_ck | input | 1 | Card clock level from the clock generator |
| host_cmd_o | input | 1 | Command level from the host datapath |
| host_cmd_oe | input | 1 | Command drive enable from the host datapath |
| host_dat_o | input | DAT_W | Data levels from the host datapath |
| host_dat_oe | input | 1 | Data drive enable from the host datapath |
| pad_ck_oe | output | 1 | Clock pad output enable |
| pad_ck_o | output | 1 | Clock pad level |
| pad_cmd_oe | output | 1 | Command pad output enable |
| pad_cmd_o | output | 1 | Command pad level |
| pad_dat_oe | output | DAT_W | Data pad output enables |
| pad_dat_o | output | DAT_W | Data pad levels |
| xcvr_cmd_dir | output | 1 | External transceiver direction, command line |
| xcvr_dat_dir | output | 1 | External transceiver direction, data lines |
| host_ready | output | 1 | Initial clock cycles complete in power-on |
| stat_code | output | 2 | Read-back of the current power code |
| stat_dirinv | output | 1 | Read-back of the polarity bit |

## Verification
Directed write sequences walk the legal bring-up path. They also try the out-of-order and reserved codes, which shows whether the state machine refuses a transition or just follows the written code. The ready flag is checked one tick short of the limit and again at the limit, then once more after a second power-on, so that an off-by-one count or a counter that is not cleared shows up. A seeded random run of writes and host datapath values is compared against a bench state model. This catches wrong pad levels or polarity in any state reached in any order.

// File: rtl/sdpwr_pkg.sv
package sdpwr_pkg;

  typedef enum logic [1:0] {
    ST_RST = 2'd0,
    ST_CYC = 2'd1,
    ST_OFF = 2'd2,
    ST_ON  = 2'd3
  } pwr_st_e;

  localparam logic [1:0] CODE_OFF = 2'b00;
  localparam logic [1:0] CODE_RSV = 2'b01;
  localparam logic [1:0] CODE_CYC = 2'b10;
  localparam logic [1:0] CODE_ON  = 2'b11;

  // software-visible code of an internal state; reset and off share 00
  function automatic logic [1:0] st_to_code(input pwr_st_e s);
    case (s)
      ST_CYC:  st_to_code = CODE_CYC;
      ST_ON:   st_to_code = CODE_ON;
      default: st_to_code = CODE_OFF;
    endcase
  endfunction

  // transition rule for an accepted write
  function automatic pwr_st_e next_state(input pwr_st_e s, input logic [1:0] c);
    case (c)
      CODE_CYC: next_state = ST_CYC;
      CODE_OFF: next_state = (s == ST_RST) ? ST_RST : ST_OFF;
      CODE_ON:  next_state = (s == ST_OFF || s == ST_ON) ? ST_ON : s;
      default:  next_state = s;
    endcase
  endfunction

endpackage

// File: rtl/sdpwr_fsm.sv
module sdpwr_fsm
  import sdpwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [1:0] code_i,
  input  logic       inv_i,
  output pwr_st_e    st_o,
  output logic       inv_o
);

  pwr_st_e st_q;
  logic    inv_q;
  logic    take;

  assign take = wr_i && (code_i != CODE_RSV);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RST;
      inv_q <= 1'b0;
    end else if (take) begin
      st_q  <= next_state(st_q, code_i);
      inv_q <= inv_i;
    end
  end

  assign st_o  = st_q;
  assign inv_o = inv_q;

  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_i && code_i == CODE_RSV) |=> ($stable(st_q) && $stable(inv_q))); // R5
  AST_ON_ORDER: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RST || st_q == ST_CYC) |=> (st_q != ST_ON)); // R4
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (st_q == ST_RST && !inv_q)); // R11

endmodule

// File: rtl/sdpwr_init_cnt.sv
module sdpwr_init_cnt #(
  parameter int INIT_CYC = 74
) (
  input  logic clk,
  input  logic rst,
  input  logic on_i,
  input  logic tick_i,
  output logic ready_o
);

  localparam int CW = $clog2(INIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] CAP  = CW'(INIT_CYC);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst || !on_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (tick_i && !rdy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) rdy_q <= 1'b1;
    end
  end

  assign ready_o = rdy_q;

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CAP); // R6
  AST_RDY_DROP: assert property (@(posedge clk) disable iff (rst)
    !on_i |=> !ready_o); // R8
  AST_RDY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(tick_i)); // R6

endmodule

// File: rtl/sdpwr_pad_drv.sv
module sdpwr_pad_drv
  import sdpwr_pkg::*;
#(
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pwr_st_e          st_i,
  input  logic             ready_i,
  input  logic             inv_i,
  input  logic             host_ck,
  input  logic             host_cmd_o,
  input  logic             host_cmd_oe,
  input  logic [DAT_W-1:0] host_dat_o,
  input  logic             host_dat_oe,
  output logic             ck_oe_o,
  output logic             ck_lvl_o,
  output logic             cmd_oe_o,
  output logic             cmd_lvl_o,
  output logic [DAT_W-1:0] dat_oe_o,
  output logic [DAT_W-1:0] dat_lvl_o,
  output logic             cmd_dir_o,
  output logic             dat_dir_o
);

  logic ck_oe_d, ck_lvl_d, ln_oe_d, ln_hi_d, own_d;
  logic ck_oe_q, ck_lvl_q, cmd_oe_q, cmd_lvl_q, cmd_dir_q, dat_dir_q;
  logic cmd_oe_d, cmd_lvl_d, dat_oe_d;
  logic [DAT_W-1:0] dat_oe_q, dat_lvl_q;

  // state-driven line behaviour shared by command and data lanes
  always_comb begin
    own_d = 1'b0;
    unique case (st_i)
      ST_CYC: begin ck_oe_d = 1'b1; ck_lvl_d = 1'b0;    ln_oe_d = 1'b1; ln_hi_d = 1'b0; end
      ST_OFF: begin ck_oe_d = 1'b1; ck_lvl_d = 1'b1;    ln_oe_d = 1'b1; ln_hi_d = 1'b1; end
      ST_ON:  begin ck_oe_d = 1'b1; ck_lvl_d = host_ck; ln_oe_d = 1'b1; ln_hi_d = 1'b1;
                    own_d = ready_i; end
      default: begin ck_oe_d = 1'b0; ck_lvl_d = 1'b0;   ln_oe_d = 1'b0; ln_hi_d = 1'b0; end
    endcase
    cmd_oe_d  = own_d ? host_cmd_oe : ln_oe_d;
    cmd_lvl_d = own_d ? host_cmd_o  : ln_hi_d;
    dat_oe_d  = own_d ? host_dat_oe : ln_oe_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_oe_q   <= 1'b0;
      ck_lvl_q  <= 1'b0;
      cmd_oe_q  <= 1'b0;
      cmd_lvl_q <= 1'b0;
      cmd_dir_q <= 1'b0;
      dat_dir_q <= 1'b0;
    end else begin
      ck_oe_q   <= ck_oe_d;
      ck_lvl_q  <= ck_lvl_d;
      cmd_oe_q  <= cmd_oe_d;
      cmd_lvl_q <= cmd_lvl_d;
      cmd_dir_q <= cmd_oe_d ^ inv_i;
      dat_dir_q <= dat_oe_d ^ inv_i;
    end
  end

  for (genvar g = 0; g < DAT_W; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        dat_oe_q[g]  <= 1'b0;
        dat_lvl_q[g] <= 1'b0;
      end else begin
        dat_oe_q[g]  <= dat_oe_d;
        dat_lvl_q[g] <= own_d ? host_dat_o[g] : ln_hi_d;
      end
    end
  end

  assign ck_oe_o   = ck_oe_q;
  assign ck_lvl_o  = ck_lvl_q;
  assign cmd_oe_o  = cmd_oe_q;
  assign cmd_lvl_o = cmd_lvl_q;
  assign dat_oe_o  = dat_oe_q;
  assign dat_lvl_o = dat_lvl_q;
  assign cmd_dir_o = cmd_dir_q;
  assign dat_dir_o = dat_dir_q;

  AST_RST_TRI: assert property (@(posedge clk) disable iff (rst)
    (st_i == ST_RST) |=> (!ck_oe_q && !cmd_oe_q && ~|dat_oe_q)); // R1
  AST_CYC_LOW: assert property (@(posedge clk) disable iff (rst)
    (st_i == ST_CYC) |=> (ck_oe_q && !ck_lvl_q && cmd_oe_q && !cmd_lvl_q
                          && &dat_oe_q && ~|dat_lvl_q)); // R2
  AST_OFF_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st_i == ST_OFF) |=> (ck_lvl_q && cmd_lvl_q && &dat_lvl_q)); // R3
  AST_HOLD_INIT: assert property (@(posedge clk) disable iff (rst)
    (st_i == ST_ON && !ready_i) |=> (cmd_oe_q && cmd_lvl_q && &dat_lvl_q)); // R6
  AST_DIR_POL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cmd_dir_q == (cmd_oe_q ^ $past(inv_i)))); // R9

endmodule

// File: rtl/sdpwr_seq_top.sv
module sdpwr_seq_top
  import sdpwr_pkg::*;
#(
  parameter int DAT_W    = 8,
  parameter int INIT_CYC = 74
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_code,
  input  logic             cfg_dirinv,
  input  logic             card_tick,
  input  logic             host_ck,
  input  logic             host_cmd_o,
  input  logic             host_cmd_oe,
  input  logic [DAT_W-1:0] host_dat_o,
  input  logic             host_dat_oe,
  output logic             pad_ck_oe,
  output logic             pad_ck_o,
  output logic             pad_cmd_oe,
  output logic             pad_cmd_o,
  output logic [DAT_W-1:0] pad_dat_oe,
  output logic [DAT_W-1:0] pad_dat_o,
  output logic             xcvr_cmd_dir,
  output logic             xcvr_dat_dir,
  output logic             host_ready,
  output logic [1:0]       stat_code,
  output logic             stat_dirinv
);

  pwr_st_e st;
  logic    inv;
  logic    rdy;

  sdpwr_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (cfg_wr),
    .code_i (cfg_code),
    .inv_i  (cfg_dirinv),
    .st_o   (st),
    .inv_o  (inv)
  );

  sdpwr_init_cnt #(.INIT_CYC(INIT_CYC)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .on_i    (st == ST_ON),
    .tick_i  (card_tick),
    .ready_o (rdy)
  );

  sdpwr_pad_drv #(.DAT_W(DAT_W)) u_pad (
    .clk         (clk),
    .rst         (rst),
    .st_i        (st),
    .ready_i     (rdy),
    .inv_i       (inv),
    .host_ck     (host_ck),
    .host_cmd_o  (host_cmd_o),
    .host_cmd_oe (host_cmd_oe),
    .host_dat_o  (host_dat_o),
    .host_dat_oe (host_dat_oe),
    .ck_oe_o     (pad_ck_oe),
    .ck_lvl_o    (pad_ck_o),
    .cmd_oe_o    (pad_cmd_oe),
    .cmd_lvl_o   (pad_cmd_o),
    .dat_oe_o    (pad_dat_oe),
    .dat_lvl_o   (pad_dat_o),
    .cmd_dir_o   (xcvr_cmd_dir),
    .dat_dir_o   (xcvr_dat_dir)
  );

  assign host_ready  = rdy;
  assign stat_code   = st_to_code(st);
  assign stat_dirinv = inv;

endmodule

// File: tb/sdpwr_seq_top_tb.sv
module sdpwr_seq_top_tb_top;

  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int NINIT = 74;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_code = 2'b00;
  logic cfg_dirinv = 1'b0;
  logic card_tick = 1'b0;
  logic host_ck = 1'b0, host_cmd_o = 1'b0, host_cmd_oe = 1'b0, host_dat_oe = 1'b0;
  logic [DW-1:0] host_dat_o = '0;
  logic pad_ck_oe, pad_ck_o, pad_cmd_oe, pad_cmd_o;
  logic [DW-1:0] pad_dat_oe, pad_dat_o;
  logic xcvr_cmd_dir, xcvr_dat_dir, host_ready, stat_dirinv;
  logic [1:0] stat_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model: 0 reset, 1 cycle, 2 off, 3 on
  int   m_st = 0;
  logic m_inv = 1'b0;
  logic m_rdy = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sdpwr_seq_top #(.DAT_W(DW), .INIT_CYC(NINIT)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_code(cfg_code), .cfg_dirinv(cfg_dirinv),
    .card_tick(card_tick), .host_ck(host_ck), .host_cmd_o(host_cmd_o),
    .host_cmd_oe(host_cmd_oe), .host_dat_o(host_dat_o), .host_dat_oe(host_dat_oe),
    .pad_ck_oe(pad_ck_oe), .pad_ck_o(pad_ck_o), .pad_cmd_oe(pad_cmd_oe),
    .pad_cmd_o(pad_cmd_o), .pad_dat_oe(pad_dat_oe), .pad_dat_o(pad_dat_o),
    .xcvr_cmd_dir(xcvr_cmd_dir), .xcvr_dat_dir(xcvr_dat_dir), .host_ready(host_ready),
    .stat_code(stat_code), .stat_dirinv(stat_dirinv)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  function automatic int model_next(input int s, input logic [1:0] c);
    case (c)
      2'b10:   return 1;
      2'b00:   return (s == 0) ? 0 : 2;
      2'b11:   return (s == 2 || s == 3) ? 3 : s;
      default: return s;
    endcase
  endfunction

  function automatic logic [1:0] model_code(input int s);
    return (s == 1) ? 2'b10 : (s == 3) ? 2'b11 : 2'b00;
  endfunction

  // write, then wait until the registered pads reflect it
  task automatic wr(input logic [1:0] c, input logic inv);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_code = c; cfg_dirinv = inv;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (c != 2'b01) begin
      m_st  = model_next(m_st, c);
      m_inv = inv;
    end
    if (m_st != 3) m_rdy = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) card_tick = 1'b1;
      @(negedge clk) card_tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_pads(input string rq);
    logic e_ckoe, e_cklv, e_oe, e_lv, own;
    logic [DW-1:0] e_dlv;
    own = (m_st == 3) && m_rdy;
    case (m_st)
      1: begin e_ckoe = 1; e_cklv = 0;       e_oe = 1; e_lv = 0; end
      2: begin e_ckoe = 1; e_cklv = 1;       e_oe = 1; e_lv = 1; end
      3: begin e_ckoe = 1; e_cklv = host_ck; e_oe = 1; e_lv = 1; end
      default: begin e_ckoe = 0; e_cklv = 0; e_oe = 0; e_lv = 0; end
    endcase
    e_dlv = {DW{e_lv}};
    check({rq, " stat_code"}, 32'(stat_code), 32'(model_code(m_st)));
    check({rq, " ck_oe"}, 32'(pad_ck_oe), 32'(e_ckoe));
    check({rq, " ck_o"}, 32'(pad_ck_o), 32'(e_cklv));
    check({rq, " cmd_oe"}, 32'(pad_cmd_oe), 32'(own ? host_cmd_oe : e_oe));
    check({rq, " cmd_o"}, 32'(pad_cmd_o), 32'(own ? host_cmd_o : e_lv));
    check({rq, " dat_oe"}, 32'(pad_dat_oe), 32'(own ? {DW{host_dat_oe}} : {DW{e_oe}}));
    check({rq, " dat_o"}, 32'(pad_dat_o), 32'(own ? host_dat_o : e_dlv));
    check({rq, " R9 cmd_dir"}, 32'(xcvr_cmd_dir), 32'((own ? host_cmd_oe : e_oe) ^ m_inv));
    check({rq, " R9 dat_dir"}, 32'(xcvr_dat_dir), 32'((own ? host_dat_oe : e_oe) ^ m_inv));
    check({rq, " R10 dirinv"}, 32'(stat_dirinv), 32'(m_inv));
    check({rq, " ready"}, 32'(host_ready), 32'(m_rdy));
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    idle(2);
    rst = 1'b0;
    m_st = 0; m_inv = 1'b0; m_rdy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd5150);
    do_reset();
    chk_pads("R1 reset");

    wr(2'b00, 1'b0);
    chk_pads("R3 off-from-reset");
    wr(2'b11, 1'b0);
    chk_pads("R4 on-from-reset");
    check("R4 on-from-reset oe", 32'(pad_cmd_oe), 32'd0);

    wr(2'b10, 1'b1);
    chk_pads("R2 cycle");
    check("R2 cycle levels", 32'({pad_ck_o, pad_cmd_o, pad_dat_o}), 32'd0);
    wr(2'b11, 1'b1);
    chk_pads("R4 on-from-cycle");
    check("R4 cycle kept", 32'(stat_code), 32'h2);
    wr(2'b01, 1'b0);
    chk_pads("R5 reserved");
    check("R5 polarity kept", 32'(stat_dirinv), 32'd1);

    wr(2'b00, 1'b0);
    chk_pads("R3 off");
    check("R3 off levels", 32'({pad_ck_o, pad_cmd_o, pad_dat_o}), 32'h3FF);

    host_ck = 1'b1; host_cmd_o = 1'b0; host_cmd_oe = 1'b0;
    host_dat_o = 8'h5A; host_dat_oe = 1'b0;
    wr(2'b11, 1'b0);
    chk_pads("R6 on held");
    ticks(NINIT - 1);
    check("R6 ready before limit", 32'(host_ready), 32'd0);
    ticks(1);
    check("R6 ready at limit", 32'(host_ready), 32'd1);
    m_rdy = 1'b1;
    @(negedge clk);
    chk_pads("R7 handed over");
    @(negedge clk) begin host_cmd_oe = 1'b1; host_cmd_o = 1'b1; host_dat_oe = 1'b1; host_dat_o = 8'hC3; end
    @(negedge clk);
    chk_pads("R7 host drive");

    wr(2'b10, 1'b0);
    check("R8 ready cleared", 32'(host_ready), 32'd0);
    wr(2'b00, 1'b0);
    wr(2'b11, 1'b0);
    ticks(NINIT - 1);
    check("R8 count restarted", 32'(host_ready), 32'd0);
    ticks(1);
    check("R8 ready again", 32'(host_ready), 32'd1);
    m_rdy = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      host_ck = r[4]; host_cmd_o = r[5]; host_cmd_oe = r[6];
      host_dat_oe = r[7]; host_dat_o = r[15:8];
      wr(r[1:0], r[2]);
      chk_pads("R2/R3/R4/R5/R7/R9 random");
    end

    wr(2'b00, 1'b0);
    wr(2'b11, 1'b1);
    do_reset();
    chk_pads("R11 reset from on");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule